// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block runs a block load or a block store of up to sixteen 32-bit registers in one command. A command carries a 16-bit register mask, a base address, a two-bit stepping mode, a load/store select and a writeback flag. The sequencer turns it into a run of single-word memory accesses, one per accepted cycle. For a load it writes each returned word into the register file. For a store it reads each register out of the register file and sends it to memory.

The mode sets where the block of words sits relative to the base. The accesses always run from the lowest address upward, one word at a time, so the lowest-numbered selected register always lands at the lowest address. When the operation ends, the sequencer raises a one-cycle done pulse. With writeback on and a non-empty mask, it also offers a new base value moved by four bytes per register. A descending-before store with writeback acts as a push. An ascending-after load with writeback acts as a pop, and it restores the pushed registers in the same order.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, mem_req, done and base_we are all 0.
- R2: Mode 2'b00 (ascending, step after; the default) makes its first access at the base, and each later access is 4 bytes above the one before.
- R3: Mode 2'b01 (ascending, step before) makes its first access at base+4 and steps upward by 4.
- R4: Mode 2'b10 (descending, step after) makes its first access at base-4n+4, where n is the number of set mask bits, so that the last access is at the base.
- R5: Mode 2'b11 (descending, step before) makes its first access at base-4n, so that the last access is at base-4.
- R6: The registers are served in rising index order of the set mask bits, whatever the mode. rf_rd_idx and rf_wr_idx give the index of the register for the current access.
- R7: For a load (is_load=1), in each cycle where mem_req and mem_ready are both high, rf_we is 1 and rf_wr_data equals mem_rdata. rf_we is 0 at all other times.
- R8: For a store (is_load=0), mem_we is 1 during the access, and mem_wdata equals the register-file word read at rf_rd_idx.
- R9: While mem_ready is low, the access holds its address and register index, and the sequencer does not advance.
- R10: In the done cycle, base_out equals base+4n for ascending modes and base-4n for descending modes. base_we is 1 only if writeback was requested and n is greater than 0.
- R11: An empty mask raises done in the cycle after start, with no memory access and base_we at 0.
- R12: done is high for exactly one cycle, in the cycle right after the last accepted access. A start input seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Accept a command when idle |
| reg_mask | input | 16 | Register select mask |
| base_addr | input | 32 | Base address |
| step_mode | input | 2 | Bit 1 selects descending, bit 0 selects step-before |
| is_load | input | 1 | 1 for load, 0 for store |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| done | output | 1 | Operation complete pulse |
| base_we | output | 1 | Write base_out back to the base register |
| base_out | output | 32 | Updated base value |

## Verification
The properties assume that memory returns mem_ready only while a request is raised, and that the command inputs matter only in the cycle where start is high. The bench holds all command inputs steady around each start. It drives mem_ready at the falling edge, either held high or toggled every other cycle, so that stalls fall at different points of each run. The bench also raises start once during a busy run, which the design must not take as a new command.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    localparam int NREG       = 16;
    localparam int XLEN       = 32;
    localparam int IDXW       = $clog2(NREG);
    localparam int CNTW       = $clog2(NREG + 1);
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        MODE_UP_AFTER    = 2'b00,
        MODE_UP_BEFORE   = 2'b01,
        MODE_DOWN_AFTER  = 2'b10,
        MODE_DOWN_BEFORE = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic is_load;
        logic wb_en;
        logic nonempty;
    } xfer_cmd_t;

    function automatic logic [CNTW-1:0] mask_count(input logic [NREG-1:0] m);
        logic [CNTW-1:0] c;
        c = '0;
        for (int i = 0; i < NREG; i++) begin
            c = c + CNTW'(m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/blk_xfer_addr.sv
module blk_xfer_addr #(
    parameter int XLEN       = 32,
    parameter int CNTW       = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0] base,
    input  logic [1:0]      mode,
    input  logic [CNTW-1:0] count,
    output logic [XLEN-1:0] low_addr,
    output logic [XLEN-1:0] new_base
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] span;

    always_comb begin
        span = {{(XLEN-CNTW){1'b0}}, count} * STEP;
        unique case (mode)
            2'b00:   low_addr = base;
            2'b01:   low_addr = base + STEP;
            2'b10:   low_addr = base - span + STEP;
            default: low_addr = base - span;
        endcase
        new_base = mode[1] ? (base - span) : (base + span);
    end
endmodule

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick #(
    parameter int NREG = 16,
    parameter int IDXW = 4
) (
    input  logic [NREG-1:0] mask,
    output logic [IDXW-1:0] idx,
    output logic            last,
    output logic [NREG-1:0] rest
);
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDXW'(i);
        end
        rest = mask & (mask - NREG'(1));
        last = (mask != '0) && (rest == '0);
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NREG-1:0] reg_mask,
    input  logic [XLEN-1:0] base_addr,
    input  logic [1:0]      step_mode,
    input  logic            is_load,
    input  logic            wb_en,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic [IDXW-1:0] rf_rd_idx,
    input  logic [XLEN-1:0] rf_rd_data,
    output logic            rf_we,
    output logic [IDXW-1:0] rf_wr_idx,
    output logic [XLEN-1:0] rf_wr_data,
    output logic            done,
    output logic            base_we,
    output logic [XLEN-1:0] base_out
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    seq_state_e      state_q;
    xfer_cmd_t       cmd_q;
    logic [NREG-1:0] remain_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] nbase_q;

    logic [CNTW-1:0] cnt_in;
    logic [XLEN-1:0] low_in;
    logic [XLEN-1:0] nbase_in;
    logic [IDXW-1:0] cur_idx;
    logic            cur_last;
    logic [NREG-1:0] cur_rest;
    logic            accept;

    assign cnt_in = mask_count(reg_mask);

    blk_xfer_addr #(
        .XLEN       (XLEN),
        .CNTW       (CNTW),
        .WORD_BYTES (WORD_BYTES)
    ) addr_i (
        .base     (base_addr),
        .mode     (step_mode),
        .count    (cnt_in),
        .low_addr (low_in),
        .new_base (nbase_in)
    );

    blk_xfer_pick #(
        .NREG (NREG),
        .IDXW (IDXW)
    ) pick_i (
        .mask (remain_q),
        .idx  (cur_idx),
        .last (cur_last),
        .rest (cur_rest)
    );

    assign accept = (state_q == ST_XFER) && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= '0;
            remain_q <= '0;
            addr_q   <= '0;
            nbase_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q.is_load  <= is_load;
                        cmd_q.wb_en    <= wb_en;
                        cmd_q.nonempty <= (reg_mask != '0);
                        remain_q       <= reg_mask;
                        addr_q         <= low_in;
                        nbase_q        <= nbase_in;
                        state_q        <= (reg_mask == '0) ? ST_DONE : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (accept) begin
                        remain_q <= cur_rest;
                        addr_q   <= addr_q + STEP;
                        if (cur_last) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign mem_req    = (state_q == ST_XFER);
    assign mem_we     = mem_req && !cmd_q.is_load;
    assign mem_addr   = addr_q;
    assign mem_wdata  = rf_rd_data;
    assign rf_rd_idx  = cur_idx;
    assign rf_wr_idx  = cur_idx;
    assign rf_we      = accept && cmd_q.is_load;
    assign rf_wr_data = mem_rdata;
    assign done       = (state_q == ST_DONE);
    assign base_we    = done && cmd_q.wb_en && cmd_q.nonempty;
    assign base_out   = nbase_q;
endmodule

// File: rtl/blk_xfer_chk.sv
module blk_xfer_chk
    import blk_xfer_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ready,
    input logic            rf_we,
    input logic [IDXW-1:0] rf_rd_idx,
    input logic            done,
    input logic            base_we
);
    // R9: a stalled access keeps its address and register index
    a_r9_hold_access: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_rd_idx)));

    // R2: every accepted access is followed by done or by the next word up
    a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (done || (mem_req && mem_addr == $past(mem_addr) + 32'd4)));

    // R6: register index rises from one access to the next
    a_r6_index_rises: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (!mem_req || rf_rd_idx > $past(rf_rd_idx)));

    // R12: done lasts one cycle and never overlaps an access
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r12_done_alone: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy && !mem_req));

    // R7: register write only on an accepted load access
    a_r7_rf_write: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    // R10: base update only together with done
    a_r10_base_we_done: assert property (@(posedge clk) disable iff (rst)
        base_we |-> done);

    // R1: the cycle after reset is idle
    a_r1_reset_idle: assert property (@(posedge clk)
        $fell(rst) |-> (!busy && !mem_req && !done && !base_we));
endmodule

bind blk_xfer_seq blk_xfer_chk chk_i (.*);

// File: tb/blk_xfer_seq_tb_top.sv
module blk_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] reg_mask = '0;
    logic [31:0] base_addr = '0;
    logic [1:0]  step_mode = '0;
    logic        is_load = 1'b0;
    logic        wb_en = 1'b0;
    logic        busy, mem_req, mem_we, rf_we, done, base_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, base_out;
    logic        mem_ready = 1'b0;
    logic [3:0]  rf_rd_idx, rf_wr_idx;

    logic [31:0] rf_model [16];
    logic [31:0] mem_model [64];
    logic        mem_wr_en = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rd_data = rf_model[rf_rd_idx];
    assign mem_rdata  = mem_model[mem_addr[7:2]];

    initial begin
        for (int i = 0; i < 16; i++) rf_model[i] = 32'hA000_0000 | i;
        for (int i = 0; i < 64; i++) mem_model[i] = 32'hC000_0000 | i;
    end

    always @(posedge clk) begin
        if (rf_we) rf_model[rf_wr_idx] <= rf_wr_data;
        if (mem_wr_en && mem_req && mem_we && mem_ready) mem_model[mem_addr[7:2]] <= mem_wdata;
    end

    blk_xfer_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .reg_mask(reg_mask),
        .base_addr(base_addr), .step_mode(step_mode), .is_load(is_load),
        .wb_en(wb_en), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .done(done), .base_we(base_we), .base_out(base_out)
    );

    typedef struct packed {
        logic [15:0] mask;
        logic [31:0] base;
        logic [1:0]  mode;
        logic        load;
        logic        wb;
        logic        stall;
        logic [31:0] first;
        logic [31:0] nbase;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h00F0, 32'h0000_1000, 2'b00, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_1010},
        '{16'h00F0, 32'h0000_1000, 2'b01, 1'b0, 1'b1, 1'b1, 32'h0000_1004, 32'h0000_1010},
        '{16'h00F0, 32'h0000_1000, 2'b10, 1'b1, 1'b1, 1'b1, 32'h0000_0FF4, 32'h0000_0FF0},
        '{16'h00F0, 32'h0000_1000, 2'b11, 1'b0, 1'b1, 1'b0, 32'h0000_0FF0, 32'h0000_0FF0},
        '{16'h8001, 32'h0000_2000, 2'b11, 1'b0, 1'b0, 1'b1, 32'h0000_1FF8, 32'h0000_1FF8},
        '{16'hFFFF, 32'h0000_4000, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_4000, 32'h0000_4040},
        '{16'h0A50, 32'h0000_0100, 2'b10, 1'b0, 1'b1, 1'b0, 32'h0000_00F4, 32'h0000_00F0},
        '{16'h0001, 32'h0000_0000, 2'b01, 1'b1, 1'b0, 1'b1, 32'h0000_0004, 32'h0000_0004}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_op(input vec_t v);
        logic [15:0] remaining;
        logic [31:0] exp_addr;
        int          e;
        bit          got_done;
        string       tg;
        tg = mode_tag(v.mode);
        reg_mask = v.mask; base_addr = v.base; step_mode = v.mode;
        is_load = v.load; wb_en = v.wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        remaining = v.mask;
        exp_addr = v.first;
        got_done = 1'b0;
        for (int cyc = 0; cyc < 200 && !got_done; cyc++) begin
            mem_ready = v.stall ? ((cyc % 2) == 1) : 1'b1;
            #1;
            if (done) begin
                got_done = 1'b1;
                check(remaining == 16'h0, "R12 done after last access", 32'(remaining), 32'h0);
                check(base_we == (v.wb && v.mask != 0), "R10 base_we", 32'(base_we), 32'(v.wb && v.mask != 0));
                check(base_out == v.nbase, "R10 base_out", base_out, v.nbase);
            end else if (mem_req) begin
                e = 0;
                for (int b = 15; b >= 0; b--) if (remaining[b]) e = b;
                check(mem_addr == exp_addr, mem_ready ? tg : "R9", mem_addr, exp_addr);
                check(rf_rd_idx == 4'(e), "R6 register order", 32'(rf_rd_idx), 32'(e));
                check(mem_we == !v.load, "R8 mem_we", 32'(mem_we), 32'(!v.load));
                if (mem_ready) begin
                    if (v.load) begin
                        check(rf_we && rf_wr_idx == 4'(e), "R7 rf write idx", 32'(rf_wr_idx), 32'(e));
                        check(rf_wr_data == mem_model[exp_addr[7:2]], "R7 rf write data", rf_wr_data, mem_model[exp_addr[7:2]]);
                    end else begin
                        check(mem_wdata == rf_model[e], "R8 store data", mem_wdata, rf_model[e]);
                    end
                    remaining[e] = 1'b0;
                    exp_addr = exp_addr + 32'd4;
                end else begin
                    check(!rf_we, "R7 no write while stalled", 32'(rf_we), 32'h0);
                end
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        #1;
        check(got_done, "R12 done seen", 32'(got_done), 32'h1);
        check(!done, "R12 done one cycle", 32'(done), 32'h0);
    endtask

    initial begin : main
        int acc;
        logic [31:0] a_first;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !mem_req && !done && !base_we, "R1 reset outputs",
              {28'h0, busy, mem_req, done, base_we}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !mem_req && !done, "R1 idle after reset", {29'h0, busy, mem_req, done}, 32'h0);

        for (int k = 0; k < NVEC; k++) run_op(VECS[k]);

        // R11: empty mask
        reg_mask = 16'h0; base_addr = 32'h0000_0700; step_mode = 2'b11;
        is_load = 1'b0; wb_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(done && !mem_req, "R11 empty done next cycle", {30'h0, done, mem_req}, 32'h2);
        check(!base_we, "R11 empty no base_we", 32'(base_we), 32'h0);
        check(base_out == 32'h0000_0700, "R11 empty base unchanged", base_out, 32'h0000_0700);
        @(negedge clk);

        // R12: start while busy is ignored
        reg_mask = 16'h0003; base_addr = 32'h0000_0500; step_mode = 2'b00;
        is_load = 1'b1; wb_en = 1'b0; start = 1'b1; mem_ready = 1'b0;
        @(negedge clk);
        reg_mask = 16'hFFFF; base_addr = 32'h0000_0900;
        @(negedge clk);
        start = 1'b0;
        acc = 0; a_first = 32'hFFFF_FFFF;
        for (int cyc = 0; cyc < 40 && !done; cyc++) begin
            mem_ready = 1'b1;
            #1;
            if (mem_req && mem_ready) begin
                if (acc == 0) a_first = mem_addr;
                acc++;
            end
            @(negedge clk);
        end
        mem_ready = 1'b0;
        check(acc == 2, "R12 start while busy ignored", 32'(acc), 32'h2);
        check(a_first == 32'h0000_0500, "R12 first address kept", a_first, 32'h0000_0500);
        @(negedge clk);

        // R5 / R2: push pair then pop into other registers
        rf_model[1] = 32'h1111_1111; rf_model[2] = 32'h2222_2222;
        mem_wr_en = 1'b1;
        run_op('{16'h0006, 32'h0000_3000, 2'b11, 1'b0, 1'b1, 1'b0, 32'h0000_2FF8, 32'h0000_2FF8});
        run_op('{16'h0030, 32'h0000_2FF8, 2'b00, 1'b1, 1'b1, 1'b1, 32'h0000_2FF8, 32'h0000_3000});
        mem_wr_en = 1'b0;
        check(rf_model[4] == 32'h1111_1111, "R5 pop order low", rf_model[4], 32'h1111_1111);
        check(rf_model[5] == 32'h2222_2222, "R2 pop order high", rf_model[5], 32'h2222_2222);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule